// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse macro without software involvement. A single-cycle start request carries a start address and a byte count. The sequencer then drives the macro's select, load, program-disable, strobe and address pins through a fixed handshake. It captures one byte per strobe into a small shadow register file and pulses `done`, returning the number of bytes it read. Each handshake phase lasts a parameterised number of microseconds, converted to clock cycles through `CLK_MHZ`.

A request has three parts. An opening guard sets up the macro. A per-byte loop follows: address setup, a strobe-high interval in which the data is taken, and a strobe-low recovery. A closing guard ends the request. A load-only mode serves macros that have no select or program-disable pins. A boot controller would normally ask for 32 bytes from address 0 and then read the fuse contents through the shadow file's read port.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset, `fuseSelN`=1, `fuseLoad`=0, `fuseProgOff`=0, `fuseStrobe`=0, `busy`=0, `done`=0 and `bytesRead`=0.
- R2: In normal mode (`loadOnly`=0), a start with a nonzero length spends one guard cycle at idle pin levels. It then drives `fuseLoad`=1, `fuseProgOff`=1 and `fuseSelN`=0 together, and holds them for OPEN_US+SETUP_US microseconds before the first strobe rises.
- R3: For each byte, `fuseAddr` holds its value for at least SETUP_US microseconds before `fuseStrobe` rises and stays stable while strobe is high. Strobe stays high for exactly HIGH_US microseconds, and the next address appears exactly LOW_US microseconds after strobe falls.
- R4: The byte read is `fuseDout` as seen in the last strobe-high cycle. It is stored in shadow entry k for the k-th byte of the request, counting from 0. The address steps by one per byte and wraps modulo 2^ADDR_W.
- R5: After the last strobe falls, the pins hold for LOW_US+TAIL_US microseconds. The close phase then lasts CLOSE_US microseconds: in normal mode `fuseSelN` returns to 1 with `fuseLoad` still 1; in load-only mode `fuseLoad` drops to 0.
- R6: For a length n>0, `done` is high for exactly one cycle. It appears 1+(OPEN_US+TAIL_US+CLOSE_US)·CLK_MHZ+n·(SETUP_US+HIGH_US+LOW_US)·CLK_MHZ cycles after the start edge. `busy` is high from that edge through the `done` cycle, then drops.
- R7: A start with length 0 raises `done` in the next cycle with `bytesRead`=0, and produces no activity on any macro pin.
- R8: In load-only mode (`loadOnly`=1 at start), `fuseSelN` stays 1 and `fuseProgOff` stays 0 for the whole request. `fuseLoad` alone frames the access.
- R9: `bytesRead` equals the smaller of the requested length and DEPTH. A longer length is clamped to DEPTH.
- R10: A start request is ignored while `busy` is high: the running sequence keeps its addresses, timing and count.
- R11: `rdData` combinationally presents shadow entry `rdIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to start a read run |
| startAddr | input | ADDR_W | First fuse address to read |
| startLen | input | LEN_W | Number of bytes to read |
| loadOnly | input | 1 | Selects load-only pin mode for this request |
| fuseDout | input | DATA_W | Data output of the fuse macro |
| fuseSelN | output | 1 | Active-low macro select |
| fuseLoad | output | 1 | Macro load/read enable |
| fuseProgOff | output | 1 | Program-disable level, high during a normal read |
| fuseStrobe | output | 1 | Read strobe |
| fuseAddr | output | ADDR_W | Macro address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| bytesRead | output | LEN_W | Bytes read by the last request, valid with done |
| rdIdx | input | $clog2(DEPTH) | Shadow file read index |
| rdData | output | DATA_W | Shadow file read data |

## Verification
Each result has a cycle in which it is due. `done` for n bytes follows the start edge by the cycle count of R6, and 0 cycles later for a zero length. Pin levels follow each state change one edge later. The bench samples every cycle on the falling edge and counts samples from the first falling edge after the start edge. It then compares the done cycle, the strobe width, the setup and recovery intervals, and the open and close guard lengths with counts worked out from the microsecond parameters. The shadow file is read back only after `done`, when its contents are settled.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARM,
    ST_OPEN,
    ST_ADDR,
    ST_STRB,
    ST_LOW,
    ST_TAIL,
    ST_CLOSE,
    ST_DONE
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;     // latch a new request
    logic capture;  // store the macro data byte
    logic advance;  // step address, pointer and remaining count
  } seq_ctl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int OPEN_US  = 2,
  parameter int SETUP_US = 2,
  parameter int HIGH_US  = 2,
  parameter int LOW_US   = 2,
  parameter int TAIL_US  = 2,
  parameter int CLOSE_US = 1,
  parameter int LEN_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] startLen,
  input  logic             loadOnly,
  input  logic             lastByte,
  output seq_ctl_t         ctl,
  output logic             pinSelN,
  output logic             pinLoad,
  output logic             pinProgOff,
  output logic             pinStrobe,
  output logic             busy,
  output logic             done
);

  localparam int OPEN_C  = OPEN_US * CLK_MHZ;
  localparam int SETUP_C = SETUP_US * CLK_MHZ;
  localparam int HIGH_C  = HIGH_US * CLK_MHZ;
  localparam int LOW_C   = LOW_US * CLK_MHZ;
  localparam int TAIL_C  = TAIL_US * CLK_MHZ;
  localparam int CLOSE_C = CLOSE_US * CLK_MHZ;
  localparam int MAX_C   = maxOf(maxOf(maxOf(OPEN_C, SETUP_C), maxOf(HIGH_C, LOW_C)),
                                 maxOf(TAIL_C, CLOSE_C));
  localparam int CNT_W   = $clog2(MAX_C + 1);

  seq_state_e       st;
  logic [CNT_W-1:0] waitCnt;
  logic             modeLoadOnly;
  logic             tick;
  logic             inner;
  logic             framed;

  assign tick = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st           <= ST_IDLE;
      waitCnt      <= '0;
      modeLoadOnly <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (startReq) begin
            modeLoadOnly <= loadOnly;
            st           <= (startLen == '0) ? ST_DONE : ST_ARM;
          end
        end
        ST_ARM: begin
          st      <= ST_OPEN;
          waitCnt <= CNT_W'(OPEN_C - 1);
        end
        ST_OPEN: begin
          if (tick) begin
            st      <= ST_ADDR;
            waitCnt <= CNT_W'(SETUP_C - 1);
          end else waitCnt <= waitCnt - 1'b1;
        end
        ST_ADDR: begin
          if (tick) begin
            st      <= ST_STRB;
            waitCnt <= CNT_W'(HIGH_C - 1);
          end else waitCnt <= waitCnt - 1'b1;
        end
        ST_STRB: begin
          if (tick) begin
            st      <= ST_LOW;
            waitCnt <= CNT_W'(LOW_C - 1);
          end else waitCnt <= waitCnt - 1'b1;
        end
        ST_LOW: begin
          if (tick) begin
            if (lastByte) begin
              st      <= ST_TAIL;
              waitCnt <= CNT_W'(TAIL_C - 1);
            end else begin
              st      <= ST_ADDR;
              waitCnt <= CNT_W'(SETUP_C - 1);
            end
          end else waitCnt <= waitCnt - 1'b1;
        end
        ST_TAIL: begin
          if (tick) begin
            st      <= ST_CLOSE;
            waitCnt <= CNT_W'(CLOSE_C - 1);
          end else waitCnt <= waitCnt - 1'b1;
        end
        ST_CLOSE: begin
          if (tick) st <= ST_DONE;
          else      waitCnt <= waitCnt - 1'b1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.take    = (st == ST_IDLE) && startReq;
    ctl.capture = (st == ST_STRB) && tick;
    ctl.advance = (st == ST_LOW) && tick;
  end

  always_comb begin
    inner      = (st == ST_OPEN) || (st == ST_ADDR) || (st == ST_STRB) ||
                 (st == ST_LOW)  || (st == ST_TAIL);
    framed     = inner || (st == ST_CLOSE);
    pinSelN    = modeLoadOnly ? 1'b1 : !inner;
    pinLoad    = modeLoadOnly ? inner : framed;
    pinProgOff = !modeLoadOnly && framed;
    pinStrobe  = (st == ST_STRB);
    busy       = (st != ST_IDLE);
    done       = (st == ST_DONE);
  end

  // R2: load, program-disable and select change together when a normal read opens
  a_r2_open_together: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pinLoad) && !modeLoadOnly) |-> (!pinSelN && pinProgOff));

  // R3: strobe only ever rises inside an open load frame
  a_r3_strobe_framed: assert property (@(posedge clk) disable iff (!rstN)
    pinStrobe |-> pinLoad);

  // R6: done is a single-cycle pulse and busy ends with it
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

endmodule

// File: rtl/fuse_seq_dp.sv
module fuse_seq_dp
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int LEN_W  = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seq_ctl_t                 ctl,
  input  logic [ADDR_W-1:0]        startAddr,
  input  logic [LEN_W-1:0]         startLen,
  input  logic [DATA_W-1:0]        fuseDout,
  input  logic [$clog2(DEPTH)-1:0] rdIdx,
  output logic [ADDR_W-1:0]        curAddr,
  output logic                     lastByte,
  output logic [LEN_W-1:0]         bytesRead,
  output logic [DATA_W-1:0]        rdData
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

  logic [PTR_W-1:0]  wrPtr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  lenClamped;
  logic [DATA_W-1:0] shadow [DEPTH];

  assign lenClamped = (startLen > DEPTH_L) ? DEPTH_L : startLen;
  assign lastByte   = (remain == LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      wrPtr     <= '0;
      remain    <= '0;
      bytesRead <= '0;
    end else if (ctl.take) begin
      curAddr   <= startAddr;
      wrPtr     <= '0;
      remain    <= lenClamped;
      bytesRead <= '0;
    end else begin
      if (ctl.capture) bytesRead <= bytesRead + 1'b1;
      if (ctl.advance) begin
        curAddr <= curAddr + 1'b1;
        wrPtr   <= wrPtr + 1'b1;
        remain  <= remain - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
    end else if (ctl.capture) begin
      shadow[wrPtr] <= fuseDout;
    end
  end

  assign rdData = shadow[rdIdx];

  // R9: the control never captures once the clamped count is used up
  a_r9_capture_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> (remain != '0));

  // R9: the returned count never exceeds the shadow file
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bytesRead <= DEPTH_L);

endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 32,
  parameter int LEN_W    = 6,
  parameter int OPEN_US  = 2,
  parameter int SETUP_US = 2,
  parameter int HIGH_US  = 2,
  parameter int LOW_US   = 2,
  parameter int TAIL_US  = 2,
  parameter int CLOSE_US = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic [ADDR_W-1:0]        startAddr,
  input  logic [LEN_W-1:0]         startLen,
  input  logic                     loadOnly,
  input  logic [DATA_W-1:0]        fuseDout,
  output logic                     fuseSelN,
  output logic                     fuseLoad,
  output logic                     fuseProgOff,
  output logic                     fuseStrobe,
  output logic [ADDR_W-1:0]        fuseAddr,
  output logic                     busy,
  output logic                     done,
  output logic [LEN_W-1:0]         bytesRead,
  input  logic [$clog2(DEPTH)-1:0] rdIdx,
  output logic [DATA_W-1:0]        rdData
);

  seq_ctl_t ctl;
  logic     lastByte;

  fuse_seq_ctrl #(
    .CLK_MHZ(CLK_MHZ), .OPEN_US(OPEN_US), .SETUP_US(SETUP_US), .HIGH_US(HIGH_US),
    .LOW_US(LOW_US), .TAIL_US(TAIL_US), .CLOSE_US(CLOSE_US), .LEN_W(LEN_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startLen(startLen),
    .loadOnly(loadOnly), .lastByte(lastByte), .ctl(ctl),
    .pinSelN(fuseSelN), .pinLoad(fuseLoad), .pinProgOff(fuseProgOff),
    .pinStrobe(fuseStrobe), .busy(busy), .done(done)
  );

  fuse_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr), .startLen(startLen),
    .fuseDout(fuseDout), .rdIdx(rdIdx), .curAddr(fuseAddr), .lastByte(lastByte),
    .bytesRead(bytesRead), .rdData(rdData)
  );

  // R3: the address does not move while the strobe is high
  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rstN)
    (fuseStrobe && $past(fuseStrobe)) |-> $stable(fuseAddr));

  // R7: a zero-length request finishes at once with the macro left alone
  a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && startLen == '0) |=> (done && !fuseLoad && !fuseStrobe && fuseSelN));

  // R10: once running, busy holds until done
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: tb/sim_fuse_read_seq.sv
module sim_fuse_read_seq;

  localparam int U      = 2;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 32;
  localparam int LEN_W  = 6;
  localparam int AMOD   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [LEN_W-1:0]  startLen = '0;
  logic loadOnly = 1'b0;
  logic [DATA_W-1:0] fuseDout;
  logic fuseSelN, fuseLoad, fuseProgOff, fuseStrobe, busy, done;
  logic [ADDR_W-1:0] fuseAddr;
  logic [LEN_W-1:0]  bytesRead;
  logic [4:0] rdIdx = '0;
  logic [DATA_W-1:0] rdData;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] fuseVal(input int a);
    int m;
    m = a % AMOD;
    return 8'((m * 29 + 7) ^ (m >> 2));
  endfunction

  // behavioural fuse macro: data valid only while strobed
  assign fuseDout = fuseStrobe ? fuseVal(int'(fuseAddr)) : 8'hEE;

  fuse_read_seq #(.CLK_MHZ(U)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .startLen(startLen), .loadOnly(loadOnly), .fuseDout(fuseDout),
    .fuseSelN(fuseSelN), .fuseLoad(fuseLoad), .fuseProgOff(fuseProgOff),
    .fuseStrobe(fuseStrobe), .fuseAddr(fuseAddr), .busy(busy), .done(done),
    .bytesRead(bytesRead), .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runReq(input int sa, input int ln, input bit lo, input bit poke);
    int n, k, c, idx, hold, width, lowCnt, openCnt, tailCnt, closeCnt, strobes, prevAddr;
    int eSetup, eWidth, eLow, eAddr, eOpen, eMode, eZero, eBusy, eShadow, gotCnt;
    bit prevStb, got, closeLvl;
    n = (ln > DEPTH) ? DEPTH : ln;
    k = (n == 0) ? 0 : 1 + 5 * U + 6 * U * n;
    c = 0; idx = 0; hold = 0; width = 0; lowCnt = 0; openCnt = 0; tailCnt = 0;
    closeCnt = 0; strobes = 0; prevAddr = -1; eSetup = 0; eWidth = 0; eLow = 0;
    eAddr = 0; eOpen = 0; eMode = 0; eZero = 0; eBusy = 0; eShadow = 0; gotCnt = 0;
    prevStb = 1'b0; got = 1'b0;
    @(negedge clk);
    startAddr = ADDR_W'(sa);
    startLen  = LEN_W'(ln);
    loadOnly  = lo;
    startReq  = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (!got && c <= k + 40) begin
      if (int'(fuseAddr) != prevAddr) hold = 1; else hold++;
      prevAddr = int'(fuseAddr);
      if (hold == 1 && idx > 0 && idx < n && !fuseStrobe && lowCnt != 2 * U) eLow++;
      if (fuseStrobe && !prevStb) begin
        strobes++;
        if (hold <= 2 * U) eSetup++;
        if (int'(fuseAddr) != (sa + idx) % AMOD) eAddr++;
        if (!lo && (fuseSelN || !fuseLoad || !fuseProgOff)) eOpen++;
        if (lo && !fuseLoad) eMode++;
        idx++;
        width = 0;
      end
      if (fuseStrobe) width++;
      if (!fuseStrobe && prevStb) begin
        if (width != 2 * U) eWidth++;
        lowCnt = 1;
      end else if (!fuseStrobe) lowCnt++;
      closeLvl = lo ? !fuseLoad : fuseSelN;
      if (busy && !done && idx == 0 && fuseLoad) openCnt++;
      if (busy && !done && idx == n && n > 0 && !fuseStrobe) begin
        if (closeLvl) closeCnt++; else tailCnt++;
      end
      if (busy && lo && (!fuseSelN || fuseProgOff)) eMode++;
      if (n == 0 && (fuseLoad || !fuseSelN || fuseProgOff || fuseStrobe)) eZero++;
      if (done) begin
        got = 1'b1;
        gotCnt = int'(bytesRead);
      end else if (!busy) eBusy++;
      if (poke && c == 5) begin
        startAddr = ADDR_W'(sa + 300);
        startLen  = LEN_W'(1);
        startReq  = 1'b1;
      end else startReq = 1'b0;
      prevStb = fuseStrobe;
      if (!got) begin
        @(negedge clk);
        c++;
      end
    end
    startReq = 1'b0;
    check(got && c == k, "R6 done cycle", c, k);
    check(eBusy == 0, "R6 busy held until done", eBusy, 0);
    check(gotCnt == n, "R9 bytes read", gotCnt, n);
    @(negedge clk);
    check(!done && !busy, "R6 single done pulse", int'(done) + int'(busy), 0);
    if (n == 0) begin
      check(eZero == 0 && strobes == 0, "R7 zero length quiet", eZero + strobes, 0);
    end else begin
      check(strobes == n && eAddr == 0, "R4 address order", eAddr + (strobes - n), 0);
      check(eSetup == 0, "R3 setup before strobe", eSetup, 0);
      check(eWidth == 0, "R3 strobe width", eWidth, 0);
      check(eLow == 0, "R3 recovery after strobe", eLow, 0);
      check(tailCnt == 4 * U, "R5 tail guard", tailCnt, 4 * U);
      check(closeCnt == U, "R5 close phase", closeCnt, U);
      if (lo) check(eMode == 0, "R8 load-only pins", eMode, 0);
      else begin
        check(eOpen == 0, "R2 open pin levels", eOpen, 0);
        check(openCnt == 4 * U, "R2 open guard", openCnt, 4 * U);
      end
      for (int i = 0; i < n; i++) begin
        rdIdx = 5'(i);
        #1;
        if (rdData != fuseVal(sa + i)) begin
          eShadow++;
          $display("FAIL R11 shadow[%0d] actual=%0d expected=%0d", i, rdData, fuseVal(sa + i));
        end
      end
      total++;
      if (eShadow != 0) bad++;
      if (poke) check(eAddr == 0 && gotCnt == n, "R10 start ignored while busy", gotCnt, n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(fuseSelN && !fuseLoad && !fuseProgOff && !fuseStrobe && !busy && !done && bytesRead == 0,
          "R1 reset levels",
          {28'd0, fuseLoad, fuseProgOff, fuseStrobe, busy} + int'(bytesRead), 0);
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 3; s++) begin
        for (int ln = 0; ln <= DEPTH; ln++) begin
          runReq((s == 0) ? 0 : ((s == 1) ? 5 : 1020), ln, m[0], 1'b0);
        end
      end
    end
    runReq(3, 33, 1'b0, 1'b0);
    runReq(9, 40, 1'b1, 1'b0);
    runReq(1010, 63, 1'b0, 1'b0);
    runReq(100, 5, 1'b0, 1'b1);
    runReq(0, 32, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule